// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out where a branch of a small 4-bit controller lands. Each request gives it the branch form, the instruction-set mode, the current 11-bit program counter, an immediate field and the nibble registers B, C, D, E, X and A. For each request it returns the next program counter, the encoded length of the branch in bytes, its machine-cycle count, and a flag that marks a request the current mode or the register contents do not allow. Fetch, opcode decode and memory access belong to the neighbouring blocks.

Requests enter on a valid/ready port and results leave on a second valid/ready port through a single register stage. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle, so a consumer that holds `rsp_ready` low stalls the producer with no loss. While `rsp_valid` is high and `rsp_ready` is low, every result field stays frozen. Form codes that each mode accepts are set by two parameter masks.

Top module: `bta_top`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `rsp_valid` is low.
- R2: A request taken on an edge (`req_valid` and `req_ready` high) produces `rsp_valid` high on the following edge. `req_ready` is low only while a held result waits (`rsp_valid` high, `rsp_ready` low). Results leave in the order requests were taken.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_pc`, `rsp_len`, `rsp_cyc` and `rsp_illegal` keep their values on the next edge.
- R4: Form code 0 (absolute) and form code 7 (extended) load `rsp_pc` with `req_imm[10:0]`, with `rsp_len` 3 and `rsp_cyc` 3.
- R5: Form code 1 (short relative) gives `req_pc + 1 + sext(req_imm[5:0])` taken modulo 2048, with `rsp_len` 1 and `rsp_cyc` 2.
- R6: Form code 2 gives `{req_pc[10:8], reg_d, reg_e}` and form code 3 gives `{req_pc[10:8], reg_x, reg_a}`, both with `rsp_len` 2 and `rsp_cyc` 3.
- R7: Form code 4 gives `{reg_c[2:0], reg_d, reg_e}` and form code 5 gives `{reg_c[2:0], reg_x, reg_a}` when `reg_b` is zero, both with `rsp_len` 2 and `rsp_cyc` 3.
- R8: For form code 4 or 5 with `reg_b` nonzero, `rsp_illegal` is 1, `rsp_pc` equals the request's `req_pc`, and `rsp_len` and `rsp_cyc` are 0.
- R9: Form code 6 (compact) loads `rsp_pc` with `req_imm[10:0]`, with `rsp_len` 2 and `rsp_cyc` 2.
- R10: With the default masks, form code 7 is illegal in mode 0 and form code 0 is illegal in mode 1. An illegal request gives `rsp_illegal` 1, `rsp_pc` equal to `req_pc`, and `rsp_len` and `rsp_cyc` 0. Every legal request gives `rsp_illegal` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_form | input | 3 | Branch form code |
| req_mode | input | 1 | Instruction-set mode (0 first, 1 second) |
| req_pc | input | 11 | Current program counter |
| req_imm | input | 11 | Immediate field of the branch |
| reg_b | input | 4 | Register B |
| reg_c | input | 4 | Register C |
| reg_d | input | 4 | Register D |
| reg_e | input | 4 | Register E |
| reg_x | input | 4 | Register X |
| reg_a | input | 4 | Register A |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_pc | output | 11 | Next program counter |
| rsp_len | output | 2 | Instruction length in bytes |
| rsp_cyc | output | 2 | Machine-cycle count |
| rsp_illegal | output | 1 | Request not allowed; program counter held |

## Verification
The bench builds the block with its default parameters: an 11-bit program counter, 4-bit registers, a 6-bit relative offset, and masks that keep form 7 out of mode 0 and form 0 out of mode 1. With these values, a relative branch from 0x7FF wraps forward to the bottom of the address space and one from 0x000 wraps back to the top. The table forms can be checked to keep the three page bits. Every form is run in both modes, so each form-and-mode pair the masks reject is driven. The consumer drops `rsp_ready` on a fixed pseudo-random pattern, so the stall and hold path is exercised between ordinary results.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic [2:0] {
    F_ABS    = 3'd0,
    F_REL    = 3'd1,
    F_TBL_DE = 3'd2,
    F_TBL_XA = 3'd3,
    F_REG_DE = 3'd4,
    F_REG_XA = 3'd5,
    F_CMP    = 3'd6,
    F_EXT    = 3'd7
  } brform_e;

  localparam int unsigned FORM_COUNT = 8;
  localparam int unsigned LEN_W = 2;
  localparam int unsigned CYC_W = 2;
endpackage

// File: rtl/bta_legal.sv
module bta_legal
  import bta_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  parameter logic [FORM_COUNT-1:0] MODE0_MASK = 8'h7F,
  parameter logic [FORM_COUNT-1:0] MODE1_MASK = 8'hFE
) (
  input  logic [2:0]       form,
  input  logic             mode,
  input  logic [NIB_W-1:0] reg_b,
  output logic             illegal,
  output logic [LEN_W-1:0] len,
  output logic [CYC_W-1:0] cyc
);
  logic [FORM_COUNT-1:0] allow_vec;
  logic                  mode_ok;
  logic                  b_clear;
  logic                  needs_b;
  logic [LEN_W-1:0]      len_raw;
  logic [CYC_W-1:0]      cyc_raw;

  // One legality bit per form, picked by mode.
  for (genvar g = 0; g < FORM_COUNT; g++) begin : g_allow
    assign allow_vec[g] = mode ? MODE1_MASK[g] : MODE0_MASK[g];
  end

  assign mode_ok = allow_vec[form];
  assign b_clear = (reg_b == '0);
  assign needs_b = (form == F_REG_DE) || (form == F_REG_XA);

  always_comb begin
    len_raw = '0;
    cyc_raw = '0;
    case (brform_e'(form))
      F_ABS, F_EXT:       begin len_raw = 2'd3; cyc_raw = 2'd3; end
      F_REL:              begin len_raw = 2'd1; cyc_raw = 2'd2; end
      F_TBL_DE, F_TBL_XA: begin len_raw = 2'd2; cyc_raw = 2'd3; end
      F_REG_DE, F_REG_XA: begin len_raw = 2'd2; cyc_raw = 2'd3; end
      F_CMP:              begin len_raw = 2'd2; cyc_raw = 2'd2; end
      default:            begin len_raw = '0;   cyc_raw = '0;   end
    endcase
  end

  assign illegal = !mode_ok || (needs_b && !b_clear);
  assign len     = illegal ? '0 : len_raw;
  assign cyc     = illegal ? '0 : cyc_raw;
endmodule

// File: rtl/bta_addr.sv
module bta_addr
  import bta_pkg::*;
#(
  parameter int unsigned PC_W  = 11,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned REL_W = 6
) (
  input  logic [2:0]       form,
  input  logic             hold,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  imm,
  input  logic [NIB_W-1:0] reg_c,
  input  logic [NIB_W-1:0] reg_d,
  input  logic [NIB_W-1:0] reg_e,
  input  logic [NIB_W-1:0] reg_x,
  input  logic [NIB_W-1:0] reg_a,
  output logic [PC_W-1:0]  target
);
  localparam int unsigned PAIR_W = 2 * NIB_W;
  localparam int unsigned PAGE_W = PC_W - PAIR_W;
  localparam int unsigned QUAD_W = 3 * NIB_W;

  logic [PAIR_W-1:0] pair_de;
  logic [PAIR_W-1:0] pair_xa;
  logic [QUAD_W-1:0] trip_cde;
  logic [QUAD_W-1:0] trip_cxa;
  logic [PC_W-1:0]   rel_off;
  logic [PC_W-1:0]   rel_tgt;
  logic [PC_W-1:0]   tbl_de;
  logic [PC_W-1:0]   tbl_xa;
  logic [PC_W-1:0]   raw;

  assign pair_de  = {reg_d, reg_e};
  assign pair_xa  = {reg_x, reg_a};
  assign trip_cde = {reg_c, reg_d, reg_e};
  assign trip_cxa = {reg_c, reg_x, reg_a};

  // Sign-extend the short offset and add it to the next instruction address.
  assign rel_off = {{(PC_W-REL_W){imm[REL_W-1]}}, imm[REL_W-1:0]};
  assign rel_tgt = pc + PC_W'(1) + rel_off;

  // Table forms keep the page bits of the current PC.
  assign tbl_de = {pc[PC_W-1 -: PAGE_W], pair_de};
  assign tbl_xa = {pc[PC_W-1 -: PAGE_W], pair_xa};

  always_comb begin
    case (brform_e'(form))
      F_ABS, F_EXT, F_CMP: raw = imm;
      F_REL:               raw = rel_tgt;
      F_TBL_DE:            raw = tbl_de;
      F_TBL_XA:            raw = tbl_xa;
      F_REG_DE:            raw = trip_cde[PC_W-1:0];
      F_REG_XA:            raw = trip_cxa[PC_W-1:0];
      default:             raw = pc;
    endcase
  end

  assign target = hold ? pc : raw;
endmodule

// File: rtl/bta_oreg.sv
module bta_oreg
  import bta_pkg::*;
#(
  parameter int unsigned PC_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [LEN_W-1:0] in_len,
  input  logic [CYC_W-1:0] in_cyc,
  input  logic             in_illegal,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PC_W-1:0]  out_pc,
  output logic [LEN_W-1:0] out_len,
  output logic [CYC_W-1:0] out_cyc,
  output logic             out_illegal
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_pc      <= '0;
      out_len     <= '0;
      out_cyc     <= '0;
      out_illegal <= 1'b0;
    end else if (load) begin
      out_pc      <= in_pc;
      out_len     <= in_len;
      out_cyc     <= in_cyc;
      out_illegal <= in_illegal;
    end
  end

  // R1: the result register comes out of reset empty.
  a_r1_empty_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  // R3: a stalled result does not move.
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pc) && $stable(out_len) &&
       $stable(out_cyc) && $stable(out_illegal)));

  // R10: a zero length goes with the illegal flag and nothing else.
  a_r10_len_flag_agree: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_illegal == (out_len == '0)));
endmodule

// File: rtl/bta_top.sv
module bta_top
  import bta_pkg::*;
#(
  parameter int unsigned PC_W  = 11,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned REL_W = 6,
  parameter logic [FORM_COUNT-1:0] MODE0_MASK = 8'h7F,
  parameter logic [FORM_COUNT-1:0] MODE1_MASK = 8'hFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_form,
  input  logic             req_mode,
  input  logic [PC_W-1:0]  req_pc,
  input  logic [PC_W-1:0]  req_imm,
  input  logic [NIB_W-1:0] reg_b,
  input  logic [NIB_W-1:0] reg_c,
  input  logic [NIB_W-1:0] reg_d,
  input  logic [NIB_W-1:0] reg_e,
  input  logic [NIB_W-1:0] reg_x,
  input  logic [NIB_W-1:0] reg_a,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PC_W-1:0]  rsp_pc,
  output logic [1:0]       rsp_len,
  output logic [1:0]       rsp_cyc,
  output logic             rsp_illegal
);
  logic             bad_w;
  logic [LEN_W-1:0] len_w;
  logic [CYC_W-1:0] cyc_w;
  logic [PC_W-1:0]  tgt_w;

  bta_legal #(
    .NIB_W(NIB_W), .MODE0_MASK(MODE0_MASK), .MODE1_MASK(MODE1_MASK)
  ) u_legal (
    .form(req_form), .mode(req_mode), .reg_b(reg_b),
    .illegal(bad_w), .len(len_w), .cyc(cyc_w)
  );

  bta_addr #(
    .PC_W(PC_W), .NIB_W(NIB_W), .REL_W(REL_W)
  ) u_addr (
    .form(req_form), .hold(bad_w), .pc(req_pc), .imm(req_imm),
    .reg_c(reg_c), .reg_d(reg_d), .reg_e(reg_e), .reg_x(reg_x), .reg_a(reg_a),
    .target(tgt_w)
  );

  bta_oreg #(.PC_W(PC_W)) u_oreg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_pc(tgt_w), .in_len(len_w), .in_cyc(cyc_w), .in_illegal(bad_w),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_pc(rsp_pc), .out_len(rsp_len), .out_cyc(rsp_cyc),
    .out_illegal(rsp_illegal)
  );

  // R2: a taken request shows up as a result on the next edge.
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R8 / R10: a rejected request leaves the program counter where it was.
  a_r8_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_w) |=>
      (rsp_illegal && rsp_pc == $past(req_pc)));
endmodule

// File: tb/sim_bta_top.sv
module sim_bta_top;
  typedef struct {
    logic [10:0] pc;
    logic [1:0]  len;
    logic [1:0]  cyc;
    logic        bad;
    int          tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_form = '0;
  logic        req_mode = 1'b0;
  logic [10:0] req_pc = '0;
  logic [10:0] req_imm = '0;
  logic [3:0]  reg_b = '0, reg_c = '0, reg_d = '0, reg_e = '0, reg_x = '0, reg_a = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [10:0] rsp_pc;
  logic [1:0]  rsp_len, rsp_cyc;
  logic        rsp_illegal;

  int   tests = 0;
  int   fails = 0;
  int   sent = 0;
  int   got = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  bta_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_form(req_form), .req_mode(req_mode), .req_pc(req_pc), .req_imm(req_imm),
    .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d), .reg_e(reg_e),
    .reg_x(reg_x), .reg_a(reg_a),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pc(rsp_pc),
    .rsp_len(rsp_len), .rsp_cyc(rsp_cyc), .rsp_illegal(rsp_illegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference result, worked out from the requirements.
  function automatic exp_t model(input int f, input bit m, input int pc, input int imm,
                                 input int b, input int c, input int d, input int e,
                                 input int x, input int a);
    exp_t r;
    int   off;
    int   t;
    bit   mode_bad;
    mode_bad = (m == 1'b0 && f == 7) || (m == 1'b1 && f == 0);
    r.bad = mode_bad || ((f == 4 || f == 5) && b != 0);
    r.tag = f;
    if (r.bad) begin
      r.pc = 11'(pc); r.len = 0; r.cyc = 0;
      r.tag = mode_bad ? 10 : 8;
      return r;
    end
    case (f)
      0, 7: begin t = imm; r.len = 3; r.cyc = 3; end
      1: begin
        off = imm % 64;
        if (off >= 32) off = off - 64;
        t = (pc + 1 + off + 4096) % 2048;
        r.len = 1; r.cyc = 2;
      end
      2: begin t = (pc / 256) * 256 + d * 16 + e; r.len = 2; r.cyc = 3; end
      3: begin t = (pc / 256) * 256 + x * 16 + a; r.len = 2; r.cyc = 3; end
      4: begin t = (c % 8) * 256 + d * 16 + e; r.len = 2; r.cyc = 3; end
      5: begin t = (c % 8) * 256 + x * 16 + a; r.len = 2; r.cyc = 3; end
      default: begin t = imm; r.len = 2; r.cyc = 2; end
    endcase
    r.pc = 11'(t);
    return r;
  endfunction

  function automatic string tagname(input int t);
    case (t)
      0, 7: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4, 5: return "R7";
      8: return "R8";
      10: return "R10";
      default: return "R9";
    endcase
  endfunction

  // Driver: present one request, wait for acceptance, push its expectation.
  task automatic send(input int f, input bit m, input int pc, input int imm,
                      input int b, input int c, input int d, input int e,
                      input int x, input int a);
    @(negedge clk);
    req_form = 3'(f); req_mode = m; req_pc = 11'(pc); req_imm = 11'(imm);
    reg_b = 4'(b); reg_c = 4'(c); reg_d = 4'(d); reg_e = 4'(e);
    reg_x = 4'(x); reg_a = 4'(a);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(model(f, m, pc, imm, b, c, d, e, x, a));
    sent++;
  endtask

  // Monitor: drives the consumer's ready, checks stalls and scoreboard order.
  initial begin : monitor
    bit         was_held = 1'b0;
    logic [10:0] h_pc;
    logic [1:0]  h_len, h_cyc;
    logic        h_bad;
    exp_t        e;
    void'($urandom(32'h5eed));
    forever begin
      @(negedge clk);
      rsp_ready = rst_n && (($urandom % 4) != 0);
      #2;
      if (rst_n && was_held) begin
        // R3: stalled result is unchanged on the next edge.
        check(rsp_valid && rsp_pc == h_pc && rsp_len == h_len &&
              rsp_cyc == h_cyc && rsp_illegal == h_bad, "R3", rsp_pc, h_pc);
      end
      if (rst_n && rsp_valid && !rsp_ready) begin
        // R2: producer stalled while a result waits.
        check(!req_ready, "R2", req_ready, 0);
      end
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", 1, 0);
        end else begin
          e = sb.pop_front();
          got++;
          check(rsp_pc == e.pc, tagname(e.tag), rsp_pc, e.pc);
          check(rsp_len == e.len && rsp_cyc == e.cyc, tagname(e.tag),
                {rsp_len, rsp_cyc}, {e.len, e.cyc});
          check(rsp_illegal == e.bad, tagname(e.bad ? e.tag : 10),
                rsp_illegal, e.bad);
        end
      end
      was_held = rst_n && rsp_valid && !rsp_ready;
      h_pc = rsp_pc; h_len = rsp_len; h_cyc = rsp_cyc; h_bad = rsp_illegal;
    end
  end

  // Watchdog.
  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2", got, sent);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: no result during reset.
    check(!rsp_valid, "R1", rsp_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(!rsp_valid, "R1", rsp_valid, 0);

    // Every form in both modes, with a few register patterns.
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 8; f++) begin
        send(f, m[0], 11'h5A3, 11'h2C7, 0, 4'hB, 4'h3, 4'hE, 4'h9, 4'h1);
        send(f, m[0], 11'h12F, 11'h035, 0, 4'h6, 4'hF, 4'h0, 4'h4, 4'hC);
      end
    end
    // R5: wrap forward and backward, extreme offsets.
    send(1, 0, 11'h7FF, 11'h000, 0, 0, 0, 0, 0, 0);
    send(1, 1, 11'h000, 11'h03E, 0, 0, 0, 0, 0, 0);
    send(1, 0, 11'h400, 11'h01F, 0, 0, 0, 0, 0, 0);
    send(1, 1, 11'h400, 11'h7E0, 0, 0, 0, 0, 0, 0);
    // R6: page bits kept at the top of the space.
    send(2, 0, 11'h7FF, 0, 0, 0, 4'h0, 4'h0, 0, 0);
    send(3, 1, 11'h700, 0, 0, 0, 0, 0, 4'hF, 4'hF);
    // R7 / R8: B zero versus each nonzero pattern bit.
    send(4, 0, 11'h111, 0, 0, 4'hF, 4'hA, 4'h5, 0, 0);
    send(4, 0, 11'h222, 0, 1, 4'h1, 4'h2, 4'h3, 0, 0);
    send(5, 1, 11'h333, 0, 8, 4'h2, 0, 0, 4'h7, 4'h7);
    send(5, 0, 11'h444, 0, 0, 4'h7, 0, 0, 4'h8, 4'h9);
    // R10: mode-rejected forms with varied PCs.
    send(7, 0, 11'h0AB, 11'h7FF, 0, 0, 0, 0, 0, 0);
    send(0, 1, 11'h6CD, 11'h001, 0, 0, 0, 0, 0, 0);
    // Back-to-back stream of mixed forms.
    for (int i = 0; i < 40; i++) begin
      send(i % 8, i[3], (i * 173) % 2048, (i * 97) % 2048, (i % 5 == 0) ? 3 : 0,
           i % 16, (i * 3) % 16, (i * 7) % 16, (i * 5) % 16, (i * 11) % 16);
    end
    @(negedge clk);
    req_valid = 1'b0;
    while (got != sent) @(negedge clk);
    repeat (2) @(negedge clk);
    check(sb.size() == 0 && !rsp_valid, "R2", sb.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule